// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. A programmable prescaler divides the system clock by `baud_div + 1` to make a sample tick. Sixteen sample ticks make one bit time. A small state machine finds the start bit, samples each later bit at its centre, and builds a character of 7 or 8 data bits, least significant bit first. It can check an even or odd parity bit, and it checks the first stop bit. The line format is set by four static control inputs, which must match the format of the far-end transmitter.

Each finished character moves from the internal shift register into a separate receive buffer. The shift register can then take in the next character while software still holds the previous one. The buffer sets a full flag and raises a one-cycle interrupt pulse. The parity error and framing error flags are captured in the same clock as the full flag. A character that finishes while the buffer is still full sets an overrun flag and is dropped. The error flags stay set until `err_clear` is pulsed or the buffer is read with `rd_strobe`.

The receive state machine has six states. `ST_IDLE` goes to `ST_START` on a falling edge of the synchronised line. `ST_START` goes back to `ST_IDLE` if the line is high at the centre sample, and goes to `ST_DATA` at the end of the bit. `ST_DATA` goes to `ST_PARITY` (parity on) or `ST_STOP1` (parity off) after the last data bit. `ST_PARITY` goes to `ST_STOP1`. `ST_STOP1` hands the character to the buffer at its centre sample. From there it goes to `ST_IDLE` in one-stop mode, or to `ST_STOP2` at the end of the bit in two-stop mode. `ST_STOP2` goes to `ST_IDLE` at its centre sample.

Top module: `uart_rx_buffered`

## Requirements
- R1: After reset, `buf_full`, `err_overrun`, `err_parity`, `err_frame` and `rx_irq` are 0, and `rd_data` is 0x00.
- R2: A sample tick occurs every `baud_div + 1` clocks, and one bit lasts 16 sample ticks. Frames are decoded correctly for any `baud_div` value.
- R3: A frame starts on a high-to-low transition of the synchronised `rxd_in`. If the line is high again at the 8th sample of the start bit, the frame is abandoned: no character, no flag and no interrupt.
- R4: Data bits are sampled at the 8th of their 16 ticks and assembled least significant bit first. With `fmt_eight_bits`=1, `rd_data[7:0]` holds all 8 received bits.
- R5: With `fmt_eight_bits`=0, 7 data bits are received into `rd_data[6:0]`, and `rd_data[7]` reads 0.
- R6: With `fmt_parity_en`=1, one parity bit follows the data. Under `fmt_parity_odd`=0 the data bits plus the parity bit must hold an even number of ones; under `fmt_parity_odd`=1 they must hold an odd number. A mismatch sets `err_parity`.
- R7: `err_frame` is set when the first stop bit samples 0. In two-stop mode (`fmt_two_stop`=1) the second stop bit is not checked.
- R8: At the centre of the first stop bit, the character goes to the buffer and `buf_full` becomes 1. The data shows on `rd_data`. A one-cycle `rd_strobe` clears `buf_full`.
- R9: `rx_irq` is a single-cycle pulse, high in the same cycle that `buf_full` is set by a new character.
- R10: If a character finishes while `buf_full` is 1 and no read happens in that cycle, `err_overrun` is set. The new character is dropped, `rd_data` keeps the old character, and no `rx_irq` pulse occurs.
- R11: The error flags are sticky. `err_clear` clears all three flags and leaves `buf_full` and `rd_data` alone. `rd_strobe` also clears all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_in | input | 1 | Serial receive line, idle high |
| fmt_eight_bits | input | 1 | 1: 8 data bits, 0: 7 data bits |
| fmt_parity_en | input | 1 | 1: a parity bit follows the data |
| fmt_parity_odd | input | 1 | 1: odd parity, 0: even parity |
| fmt_two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| baud_div | input | DIV_W | Prescaler value n; one sample tick every n+1 clocks |
| rd_strobe | input | 1 | One-cycle read of the receive buffer |
| err_clear | input | 1 | One-cycle clear of all error flags |
| rd_data | output | DATA_W | Receive buffer contents |
| buf_full | output | 1 | Receive buffer holds an unread character |
| err_overrun | output | 1 | A character was lost because the buffer was full |
| err_parity | output | 1 | Parity mismatch in the buffered character |
| err_frame | output | 1 | First stop bit of the buffered character was 0 |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
Some rules are checked by assertions on every cycle:
- the interrupt pulse never appears without the full flag;
- a read with no new character empties the buffer;
- an overrun sets its flag and keeps the buffer data unchanged;
- a clear request drops every error flag;
- a start bit that is high at its centre sends the machine back to idle.

Other behaviour can only be shown by the bench's scenarios:
- correct bit order and centre sampling at several prescaler values;
- the 7-bit top-bit masking;
- the result of the parity check for both parity senses;
- the framing check being limited to the first stop bit;
- recovery after an abandoned glitch.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OVERSAMPLE = 16;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP1  = 3'd4,
        ST_STOP2  = 3'd5
    } rx_state_t;

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             restart,
    output logic             tick
);

    logic [DIV_W-1:0] div_cnt;

    // One tick every baud_div + 1 clocks; a restart realigns the phase to a start edge.
    assign tick = (div_cnt >= baud_div) && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (restart || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_s,
    input  logic              fall,
    input  logic              tick,
    input  logic              eight_bits,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    output logic              restart,
    output logic              char_done,
    output logic [DATA_W-1:0] char_data,
    output logic              char_perr,
    output logic              char_ferr
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(DATA_W - 2);

    rx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  smp_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              perr_q;
    logic              at_mid, at_end, last_bit;

    assign at_mid   = (smp_cnt == MID_C);
    assign at_end   = (smp_cnt == LAST_C);
    assign last_bit = (bit_idx == (eight_bits ? IDX_LONG : IDX_SHORT));

    // Short mode: data sits in the upper bits after one shift fewer; realign, zero the top bit.
    assign char_data = eight_bits ? shreg : {1'b0, shreg[DATA_W-1:1]};
    assign char_perr = perr_q;
    assign char_ferr = ~rxd_s;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        restart   = 1'b0;
        char_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fall) begin
                    state_d = ST_START;
                    restart = 1'b1;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (at_mid && rxd_s) begin
                        state_d = ST_IDLE;
                    end else if (at_end) begin
                        state_d = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (tick && at_end && last_bit) begin
                    state_d = par_en ? ST_PARITY : ST_STOP1;
                end
            end
            ST_PARITY: begin
                if (tick && at_end) begin
                    state_d = ST_STOP1;
                end
            end
            ST_STOP1: begin
                if (tick) begin
                    if (at_mid) begin
                        char_done = 1'b1;
                        if (!two_stop) begin
                            state_d = ST_IDLE;
                        end
                    end else if (at_end) begin
                        state_d = ST_STOP2;
                    end
                end
            end
            ST_STOP2: begin
                if (tick && at_mid) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sample counter, bit index, shift register, parity result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_cnt <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            perr_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                smp_cnt <= '0;
            end else if (tick) begin
                smp_cnt <= smp_cnt + 1'b1;
            end
            if (state_q == ST_START) begin
                bit_idx <= '0;
                perr_q  <= 1'b0;
            end
            if (state_q == ST_DATA && tick) begin
                if (at_mid) begin
                    shreg <= {rxd_s, shreg[DATA_W-1:1]};
                end
                if (at_end) begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
            if (state_q == ST_PARITY && tick && at_mid) begin
                perr_q <= (^char_data) ^ rxd_s ^ par_odd;
            end
        end
    end

    AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && tick && at_mid && rxd_s) |=> (state_q == ST_IDLE)); // R3

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_perr,
    input  logic              char_ferr,
    input  logic              rd_strobe,
    input  logic              err_clear,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              err_overrun,
    output logic              err_parity,
    output logic              err_frame,
    output logic              rx_irq
);

    logic load, clr_flags;
    logic ovr_base, par_base, frm_base;

    // A read in the same cycle frees the buffer for the arriving character.
    assign load      = char_done && (!buf_full || rd_strobe);
    assign clr_flags = rd_strobe || err_clear;
    assign ovr_base  = err_overrun && !clr_flags;
    assign par_base  = err_parity  && !clr_flags;
    assign frm_base  = err_frame   && !clr_flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data     <= '0;
            buf_full    <= 1'b0;
            err_overrun <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            rx_irq      <= 1'b0;
        end else begin
            rx_irq <= load;
            if (load) begin
                rd_data     <= char_data;
                buf_full    <= 1'b1;
                err_overrun <= ovr_base;
                err_parity  <= par_base | char_perr;
                err_frame   <= frm_base | char_ferr;
            end else begin
                if (rd_strobe) begin
                    buf_full <= 1'b0;
                end
                err_overrun <= ovr_base | char_done;
                err_parity  <= par_base;
                err_frame   <= frm_base;
            end
        end
    end

    AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> buf_full); // R9

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !char_done) |=> !buf_full); // R8

    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && buf_full && !rd_strobe) |=> (err_overrun && $stable(rd_data) && !rx_irq)); // R10

    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !char_done) |=> (!err_overrun && !err_parity && !err_frame)); // R11

endmodule

// File: rtl/uart_rx_buffered.sv
module uart_rx_buffered
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_in,
    input  logic              fmt_eight_bits,
    input  logic              fmt_parity_en,
    input  logic              fmt_parity_odd,
    input  logic              fmt_two_stop,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              rd_strobe,
    input  logic              err_clear,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              err_overrun,
    output logic              err_parity,
    output logic              err_frame,
    output logic              rx_irq
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxd_prev;
    logic                   rxd_s, fall, tick, restart;
    logic                   char_done, char_perr, char_ferr;
    logic [DATA_W-1:0]      char_data;

    // Input synchroniser with idle-high reset, plus a delayed copy for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= '1;
            rxd_prev <= 1'b1;
        end else begin
            sync_q   <= {sync_q[SYNC_STAGES-2:0], rxd_in};
            rxd_prev <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rxd_s = sync_q[SYNC_STAGES-1];
    assign fall  = rxd_prev && !rxd_s;

    uart_rx_baud #(.DIV_W(DIV_W)) baud_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .baud_div (baud_div),
        .restart  (restart),
        .tick     (tick)
    );

    uart_rx_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd_s      (rxd_s),
        .fall       (fall),
        .tick       (tick),
        .eight_bits (fmt_eight_bits),
        .par_en     (fmt_parity_en),
        .par_odd    (fmt_parity_odd),
        .two_stop   (fmt_two_stop),
        .restart    (restart),
        .char_done  (char_done),
        .char_data  (char_data),
        .char_perr  (char_perr),
        .char_ferr  (char_ferr)
    );

    uart_rx_buffer #(.DATA_W(DATA_W)) buf_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .char_done   (char_done),
        .char_data   (char_data),
        .char_perr   (char_perr),
        .char_ferr   (char_ferr),
        .rd_strobe   (rd_strobe),
        .err_clear   (err_clear),
        .rd_data     (rd_data),
        .buf_full    (buf_full),
        .err_overrun (err_overrun),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .rx_irq      (rx_irq)
    );

endmodule

// File: tb/uart_rx_buffered_tb_top.sv
module uart_rx_buffered_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 12;
    localparam int NV = 7;
    localparam int WATCHDOG_CYC = 150000;

    typedef struct packed {
        logic       eight;
        logic       pen;
        logic       podd;
        logic       two;
        logic       bad_par;
        logic       bad_s1;
        logic       bad_s2;
        logic [3:0] div;
        logic [7:0] data;
        logic [7:0] exp_data;
        logic       exp_perr;
        logic       exp_ferr;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 8'hA5, 8'hA5, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h3C, 8'h3C, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 8'h81, 8'h81, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 8'hFF, 8'h7F, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 8'h5A, 8'h5A, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3, 8'hC3, 8'hC3, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'h55, 8'h55, 1'b0, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rxd_in = 1'b1;
    logic             fmt_eight_bits = 1'b1;
    logic             fmt_parity_en = 1'b0;
    logic             fmt_parity_odd = 1'b0;
    logic             fmt_two_stop = 1'b0;
    logic [DIV_W-1:0] baud_div = '0;
    logic             rd_strobe = 1'b0;
    logic             err_clear = 1'b0;
    logic [7:0]       rd_data;
    logic             buf_full, err_overrun, err_parity, err_frame, rx_irq;

    int checks = 0;
    int failures = 0;
    int irq_count = 0;
    int cycles = 0;
    bit done = 1'b0;

    uart_rx_buffered #(.DATA_W(8), .DIV_W(DIV_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .rxd_in         (rxd_in),
        .fmt_eight_bits (fmt_eight_bits),
        .fmt_parity_en  (fmt_parity_en),
        .fmt_parity_odd (fmt_parity_odd),
        .fmt_two_stop   (fmt_two_stop),
        .baud_div       (baud_div),
        .rd_strobe      (rd_strobe),
        .err_clear      (err_clear),
        .rd_data        (rd_data),
        .buf_full       (buf_full),
        .err_overrun    (err_overrun),
        .err_parity     (err_parity),
        .err_frame      (err_frame),
        .rx_irq         (rx_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && rx_irq) irq_count <= irq_count + 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic hold_bit(input logic val, input int div);
        rxd_in = val;
        repeat (16 * (div + 1)) @(negedge clk);
    endtask

    task automatic send_frame(input vec_t v);
        logic [7:0] d;
        logic       p;
        int         nbits;
        nbits = v.eight ? 8 : 7;
        d = v.eight ? v.data : {1'b0, v.data[6:0]};
        p = (^d) ^ v.podd ^ v.bad_par;
        @(negedge clk);
        fmt_eight_bits = v.eight;
        fmt_parity_en  = v.pen;
        fmt_parity_odd = v.podd;
        fmt_two_stop   = v.two;
        baud_div       = DIV_W'(v.div);
        hold_bit(1'b1, int'(v.div));
        hold_bit(1'b0, int'(v.div));
        for (int i = 0; i < nbits; i++) hold_bit(d[i], int'(v.div));
        if (v.pen) hold_bit(p, int'(v.div));
        hold_bit(!v.bad_s1, int'(v.div));
        if (v.two) hold_bit(!v.bad_s2, int'(v.div));
        hold_bit(1'b1, int'(v.div));
        hold_bit(1'b1, int'(v.div));
    endtask

    task automatic pulse_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        while (!done && cycles < WATCHDOG_CYC) @(negedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int irq_before;
        vec_t v;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "buf_full", int'(buf_full), 0);
        check("R1", "flags", int'({err_overrun, err_parity, err_frame}), 0);
        check("R1", "rx_irq", int'(rx_irq), 0);
        check("R1", "rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Vector table: R2 divider values, R4 order, R5 short mode, R6 parity, R7 framing, R8, R9
        for (int k = 0; k < NV; k++) begin
            irq_before = irq_count;
            send_frame(VECS[k]);
            check("R8", $sformatf("v%0d buf_full", k), int'(buf_full), 1);
            check("R2 R4 R5", $sformatf("v%0d data", k), int'(rd_data), int'(VECS[k].exp_data));
            check("R6", $sformatf("v%0d err_parity", k), int'(err_parity), int'(VECS[k].exp_perr));
            check("R7", $sformatf("v%0d err_frame", k), int'(err_frame), int'(VECS[k].exp_ferr));
            check("R10", $sformatf("v%0d err_overrun", k), int'(err_overrun), 0);
            check("R9", $sformatf("v%0d irq pulses", k), irq_count - irq_before, 1);
            pulse_read();
            check("R8", $sformatf("v%0d buf_full after read", k), int'(buf_full), 0);
            check("R11", $sformatf("v%0d flags after read", k),
                  int'({err_overrun, err_parity, err_frame}), 0);
        end

        // R3: short low glitch is abandoned, receiver then recovers
        irq_before = irq_count;
        @(negedge clk);
        baud_div = DIV_W'(3);
        fmt_eight_bits = 1'b1; fmt_parity_en = 1'b0; fmt_two_stop = 1'b0;
        rxd_in = 1'b0;
        repeat (10) @(negedge clk);
        rxd_in = 1'b1;
        repeat (200) @(negedge clk);
        check("R3", "glitch buf_full", int'(buf_full), 0);
        check("R3", "glitch irq", irq_count - irq_before, 0);
        check("R3", "glitch flags", int'({err_overrun, err_parity, err_frame}), 0);
        v = VECS[0];
        v.data = 8'h96;
        send_frame(v);
        check("R3", "recovery data", int'(rd_data), 8'h96);

        // R10: second character while full is dropped
        irq_before = irq_count;
        v.data = 8'h11;
        send_frame(v);
        check("R10", "overrun flag", int'(err_overrun), 1);
        check("R10", "old data kept", int'(rd_data), 8'h96);
        check("R10", "no irq on overrun", irq_count - irq_before, 0);
        check("R10", "still full", int'(buf_full), 1);

        // R11: err_clear drops flags but keeps the buffer
        @(negedge clk);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        @(negedge clk);
        check("R11", "overrun cleared", int'(err_overrun), 0);
        check("R11", "full kept", int'(buf_full), 1);
        check("R11", "data kept", int'(rd_data), 8'h96);
        pulse_read();
        check("R8", "final read empties", int'(buf_full), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule